// File: doc/BRIEF.md
# Byte-Lane Delay Setting Stepper

This block keeps the delay setting of one byte lane as four stacked fields: a one-bit coarse field, a clock-delay field from 0 to 2, a tap field, and an interpolator phase from 0 to 6. The fields run like a mixed-radix counter. An up or down request moves the setting by one interpolator unit. When a field overflows or underflows, the move carries into or borrows from the field above it. The largest tap value depends on the selected speed grade. A carry into the coarse field is irregular: it lowers the clock-delay field by one instead of clearing it.

Each time the setting changes, the block works out two bypass-control bits, an enable and a select. It derives them from the tap and interpolator values, compared against thresholds that depend on the speed grade. A training sequencer drives the block. It loads a starting point, then walks the setting up or down one step at a time. After every accepted step it receives a done pulse. If a step would leave the legal range, it receives an error pulse instead, and the setting stays where it was.

Top module: `dly_step_unit`

## Requirements
- R1: After a synchronous active-low reset, all four fields are 0, both bypass bits are 1, and the done and error pulses are 0.
- R2: An up step with the interpolator below 6 adds one to the interpolator and leaves the other fields alone.
- R3: An up step with the interpolator at 6 and the tap below the grade's tap maximum clears the interpolator and adds one to the tap. The tap maximum is 12 for grade 0, 10 for grade 1, 13 for grade 2, and 12 for grade 3.
- R4: An up step with the interpolator at 6 and the tap at or above its maximum behaves as follows. If clock delay is below 2, it clears tap and interpolator and adds one to clock delay. If clock delay is 2 and coarse is 0, it clears tap and interpolator, lowers clock delay to 1 and sets coarse to 1. If coarse is already 1, the step is rejected.
- R5: A down step mirrors R2 to R4. With interpolator above 0, it subtracts one from the interpolator. With interpolator at 0 and tap above 0, it sets the interpolator to 6 and subtracts one from the tap. With interpolator and tap both at 0 and clock delay above 0, it sets the interpolator to 6, sets the tap to the grade maximum and subtracts one from clock delay. With interpolator, tap and clock delay all at 0 and coarse at 1, it sets the interpolator to 6 and the tap to the maximum, adds one to clock delay and clears coarse.
- R6: A down step from the all-zero setting is rejected. A rejected step in either direction leaves all fields and both bypass bits unchanged.
- R7: After a setting change, the bypass bits follow three rules, applied in this order. (enable=1, select=1) when tap < T0, or tap == T0 and interpolator < P0. Otherwise (0,0) when tap < T1, or tap == T1 and interpolator < P1. Otherwise (1,0). The thresholds (T0, T1, P0, P1) are (3,10,2,3) for grade 0, (2,8,6,7) for grade 1, (3,11,6,4) for grade 2, and the grade 0 values for grade 3.
- R8: Up and down requested in the same cycle are ignored. The setting holds, and neither done nor error pulses.
- R9: A load request writes all four fields from the load inputs and recomputes the bypass bits. It takes priority over any step request in the same cycle and pulses neither done nor error.
- R10: A one-cycle done pulse follows every accepted step, and a one-cycle error pulse follows every rejected step, in the cycle the result becomes visible. Both are 0 in any other cycle.
- R11: Changing the speed grade alone does not change the bypass bits. They are recomputed only when a load or an accepted step occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grade_i | input | 2 | Speed grade select |
| up_i | input | 1 | Step-up request |
| down_i | input | 1 | Step-down request |
| load_i | input | 1 | Load request for all fields |
| ld_coarse_i | input | 1 | Coarse value to load |
| ld_clkd_i | input | 2 | Clock-delay value to load |
| ld_tap_i | input | 4 | Tap value to load |
| ld_pi_i | input | 3 | Interpolator value to load |
| coarse_o | output | 1 | Coarse field |
| clkd_o | output | 2 | Clock-delay field |
| tap_o | output | 4 | Tap field |
| pi_o | output | 3 | Interpolator field |
| byp_en_o | output | 1 | Bypass enable bit |
| byp_sel_o | output | 1 | Bypass select bit |
| done_o | output | 1 | Accepted-step pulse |
| err_o | output | 1 | Rejected-step pulse |

## Verification
A request sampled at one clock edge shows at that same edge: the new field values, the bypass bits and the done or error pulse all appear together, one register stage after the request. The bench therefore changes inputs on the falling edge, reads every output on the following falling edge, and only then releases the request. An idle cycle separates operations, so a pulse that lasts too long shows up in the next check. Checks after a grade-only change are made after a full idle cycle with no load or step, which confirms that the bypass bits held.

// File: rtl/dly_step_pkg.sv
// Package: shared widths, setting type and speed-grade tables for the
// byte-lane delay stepper. Assumes four grade codes, code 3 aliasing code 0.
package dly_step_pkg;

    localparam int GRADE_W  = 2;
    localparam int COARSE_W = 1;
    localparam int CLKD_W   = 2;
    localparam int TAP_W    = 4;
    localparam int PI_W     = 3;

    // One complete lane delay setting, most significant field first.
    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [CLKD_W-1:0]   clkd;
        logic [TAP_W-1:0]    tap;
        logic [PI_W-1:0]     pi;
    } dly_set_t;

    // Bypass decision thresholds for one speed grade.
    typedef struct packed {
        logic [TAP_W-1:0] t_lo;
        logic [TAP_W-1:0] t_hi;
        logic [PI_W-1:0]  p_lo;
        logic [PI_W-1:0]  p_hi;
    } byp_thr_t;

    // Largest tap value reachable for a speed grade.
    function automatic logic [TAP_W-1:0] tap_ceiling(input logic [GRADE_W-1:0] g);
        case (g)
            2'd1:    tap_ceiling = TAP_W'(10);
            2'd2:    tap_ceiling = TAP_W'(13);
            default: tap_ceiling = TAP_W'(12);
        endcase
    endfunction

    // Bypass thresholds for a speed grade.
    function automatic byp_thr_t byp_table(input logic [GRADE_W-1:0] g);
        byp_thr_t r;
        case (g)
            2'd1: begin
                r.t_lo = TAP_W'(2);  r.t_hi = TAP_W'(8);
                r.p_lo = PI_W'(6);   r.p_hi = PI_W'(7);
            end
            2'd2: begin
                r.t_lo = TAP_W'(3);  r.t_hi = TAP_W'(11);
                r.p_lo = PI_W'(6);   r.p_hi = PI_W'(4);
            end
            default: begin
                r.t_lo = TAP_W'(3);  r.t_hi = TAP_W'(10);
                r.p_lo = PI_W'(2);   r.p_hi = PI_W'(3);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dly_step_up.sv
// Module: dly_step_up
// Computes the setting one interpolator unit above the current one, with
// carry through tap, clock delay and coarse. The carry into coarse lowers
// clock delay by one. Assumes the current setting holds legal field values.
module dly_step_up
    import dly_step_pkg::*;
#(
    parameter int PI_TOP     = 6,
    parameter int CLKD_TOP   = 2,
    parameter int COARSE_TOP = 1
) (
    input  dly_set_t            cur_i,
    input  logic [TAP_W-1:0]    tap_top_i,
    output dly_set_t            nxt_o,
    output logic                ok_o
);

    // Carry chain: choose the lowest field that still has headroom.
    always_comb begin
        nxt_o = cur_i;
        ok_o  = 1'b1;
        if (cur_i.pi < PI_W'(PI_TOP)) begin
            nxt_o.pi = cur_i.pi + PI_W'(1);
        end else if (cur_i.tap < tap_top_i) begin
            nxt_o.pi  = '0;
            nxt_o.tap = cur_i.tap + TAP_W'(1);
        end else if (cur_i.clkd < CLKD_W'(CLKD_TOP)) begin
            nxt_o.pi   = '0;
            nxt_o.tap  = '0;
            nxt_o.clkd = cur_i.clkd + CLKD_W'(1);
        end else if (cur_i.coarse < COARSE_W'(COARSE_TOP)) begin
            nxt_o.pi     = '0;
            nxt_o.tap    = '0;
            nxt_o.clkd   = cur_i.clkd - CLKD_W'(1);
            nxt_o.coarse = cur_i.coarse + COARSE_W'(1);
        end else begin
            ok_o = 1'b0;
        end
    end

endmodule

// File: rtl/dly_step_down.sv
// Module: dly_step_down
// Computes the setting one interpolator unit below the current one, with
// borrow through tap, clock delay and coarse. The borrow from coarse raises
// clock delay by one. Assumes the current setting holds legal field values.
module dly_step_down
    import dly_step_pkg::*;
#(
    parameter int PI_TOP = 6
) (
    input  dly_set_t            cur_i,
    input  logic [TAP_W-1:0]    tap_top_i,
    output dly_set_t            nxt_o,
    output logic                ok_o
);

    // Borrow chain: take from the lowest non-zero field.
    always_comb begin
        nxt_o = cur_i;
        ok_o  = 1'b1;
        if (cur_i.pi != '0) begin
            nxt_o.pi = cur_i.pi - PI_W'(1);
        end else if (cur_i.tap != '0) begin
            nxt_o.pi  = PI_W'(PI_TOP);
            nxt_o.tap = cur_i.tap - TAP_W'(1);
        end else if (cur_i.clkd != '0) begin
            nxt_o.pi   = PI_W'(PI_TOP);
            nxt_o.tap  = tap_top_i;
            nxt_o.clkd = cur_i.clkd - CLKD_W'(1);
        end else if (cur_i.coarse != '0) begin
            nxt_o.pi     = PI_W'(PI_TOP);
            nxt_o.tap    = tap_top_i;
            nxt_o.clkd   = cur_i.clkd + CLKD_W'(1);
            nxt_o.coarse = cur_i.coarse - COARSE_W'(1);
        end else begin
            ok_o = 1'b0;
        end
    end

endmodule

// File: rtl/dly_byp_decode.sv
// Module: dly_byp_decode
// Maps a tap/interpolator pair onto the bypass enable and select bits using
// two threshold points. The low point is tested first. Purely combinational.
module dly_byp_decode
    import dly_step_pkg::*;
(
    input  logic [TAP_W-1:0] tap_i,
    input  logic [PI_W-1:0]  pi_i,
    input  byp_thr_t         thr_i,
    output logic             en_o,
    output logic             sel_o
);

    logic below_lo;
    logic below_hi;

    // Position of the setting relative to each threshold point.
    always_comb begin
        below_lo = (tap_i < thr_i.t_lo) || ((tap_i == thr_i.t_lo) && (pi_i < thr_i.p_lo));
        below_hi = (tap_i < thr_i.t_hi) || ((tap_i == thr_i.t_hi) && (pi_i < thr_i.p_hi));
    end

    // Region to bit-pair mapping.
    always_comb begin
        if (below_lo) begin
            en_o  = 1'b1;
            sel_o = 1'b1;
        end else if (below_hi) begin
            en_o  = 1'b0;
            sel_o = 1'b0;
        end else begin
            en_o  = 1'b1;
            sel_o = 1'b0;
        end
    end

endmodule

// File: rtl/dly_step_unit.sv
// Module: dly_step_unit (top)
// Holds one byte lane's delay setting and steps it up or down on request.
// Load wins over steps; simultaneous up and down are ignored. Bypass bits
// are refreshed only when the setting is written. Assumes the sequencer
// loads legal field values.
module dly_step_unit
    import dly_step_pkg::*;
#(
    parameter int PI_TOP     = 6,
    parameter int CLKD_TOP   = 2,
    parameter int COARSE_TOP = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRADE_W-1:0]  grade_i,
    input  logic                up_i,
    input  logic                down_i,
    input  logic                load_i,
    input  logic [COARSE_W-1:0] ld_coarse_i,
    input  logic [CLKD_W-1:0]   ld_clkd_i,
    input  logic [TAP_W-1:0]    ld_tap_i,
    input  logic [PI_W-1:0]     ld_pi_i,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [CLKD_W-1:0]   clkd_o,
    output logic [TAP_W-1:0]    tap_o,
    output logic [PI_W-1:0]     pi_o,
    output logic                byp_en_o,
    output logic                byp_sel_o,
    output logic                done_o,
    output logic                err_o
);

    dly_set_t          set_q;
    dly_set_t          up_set;
    dly_set_t          dn_set;
    dly_set_t          nxt_set;
    logic              up_ok;
    logic              dn_ok;
    logic              step_req;
    logic              step_ok;
    logic              wr_en;
    logic              byp_en_d;
    logic              byp_sel_d;
    logic              byp_en_q;
    logic              byp_sel_q;
    logic              done_q;
    logic              err_q;
    logic [TAP_W-1:0]  tap_top;
    byp_thr_t          thr;

    // Grade-dependent limits.
    always_comb begin
        tap_top = tap_ceiling(grade_i);
        thr     = byp_table(grade_i);
    end

    dly_step_up #(
        .PI_TOP     (PI_TOP),
        .CLKD_TOP   (CLKD_TOP),
        .COARSE_TOP (COARSE_TOP)
    ) u_up (
        .cur_i     (set_q),
        .tap_top_i (tap_top),
        .nxt_o     (up_set),
        .ok_o      (up_ok)
    );

    dly_step_down #(
        .PI_TOP (PI_TOP)
    ) u_dn (
        .cur_i     (set_q),
        .tap_top_i (tap_top),
        .nxt_o     (dn_set),
        .ok_o      (dn_ok)
    );

    // Request arbitration and next-setting selection.
    always_comb begin
        step_req = !load_i && (up_i ^ down_i);
        step_ok  = up_i ? up_ok : dn_ok;
        wr_en    = load_i || (step_req && step_ok);
        if (load_i) begin
            nxt_set.coarse = ld_coarse_i;
            nxt_set.clkd   = ld_clkd_i;
            nxt_set.tap    = ld_tap_i;
            nxt_set.pi     = ld_pi_i;
        end else if (up_i) begin
            nxt_set = up_set;
        end else begin
            nxt_set = dn_set;
        end
    end

    dly_byp_decode u_byp (
        .tap_i (nxt_set.tap),
        .pi_i  (nxt_set.pi),
        .thr_i (thr),
        .en_o  (byp_en_d),
        .sel_o (byp_sel_d)
    );

    // Setting and bypass register, written on load or accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q     <= '0;
            byp_en_q  <= 1'b1;
            byp_sel_q <= 1'b1;
        end else if (wr_en) begin
            set_q     <= nxt_set;
            byp_en_q  <= byp_en_d;
            byp_sel_q <= byp_sel_d;
        end
    end

    // Outcome pulses for step requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= step_req && step_ok;
            err_q  <= step_req && !step_ok;
        end
    end

    assign coarse_o  = set_q.coarse;
    assign clkd_o    = set_q.clkd;
    assign tap_o     = set_q.tap;
    assign pi_o      = set_q.pi;
    assign byp_en_o  = byp_en_q;
    assign byp_sel_o = byp_sel_q;
    assign done_o    = done_q;
    assign err_o     = err_q;

    // R6: a rejected step leaves the setting untouched.
    p_reject_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(set_q) && $stable(byp_en_q) && $stable(byp_sel_q)));

    // R7: the (enable=0, select=1) pair is never produced.
    p_byp_pair_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp_sel_o && !byp_en_o));

    // R8: both step requests together give no outcome pulse.
    p_both_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && down_i && !load_i) |=> (!done_o && !err_o && $stable(set_q)));

    // R9: load copies the load inputs and pulses nothing.
    p_load_copies_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tap_o == $past(ld_tap_i) && pi_o == $past(ld_pi_i) &&
                    clkd_o == $past(ld_clkd_i) && coarse_o == $past(ld_coarse_i) &&
                    !done_o && !err_o));

    // R10: exactly one outcome pulse follows a single step request.
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_i ^ down_i) && !load_i) |=> (done_o ^ err_o));

    // R11: without load or step the setting and bypass bits hold.
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_i && !down_i && !load_i) |=> ($stable(set_q) && $stable(byp_en_q) &&
                                          $stable(byp_sel_q) && !done_o && !err_o));

endmodule

// File: tb/dly_step_unit_bench.sv
// Bench for dly_step_unit: random operation mix with fixed seed plus directed
// boundary cases; expected values from a bench-side model of the requirements.
module dly_step_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] grade_i = 2'd0;
    logic       up_i = 1'b0;
    logic       down_i = 1'b0;
    logic       load_i = 1'b0;
    logic       ld_coarse_i = 1'b0;
    logic [1:0] ld_clkd_i = 2'd0;
    logic [3:0] ld_tap_i = 4'd0;
    logic [2:0] ld_pi_i = 3'd0;
    logic       coarse_o;
    logic [1:0] clkd_o;
    logic [3:0] tap_o;
    logic [2:0] pi_o;
    logic       byp_en_o;
    logic       byp_sel_o;
    logic       done_o;
    logic       err_o;

    int checks = 0;
    int fails  = 0;

    // Model state.
    int m_co, m_cd, m_tp, m_pi, m_en, m_sel, m_done, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_step_unit u_dly_step_unit (
        .clk(clk), .rst_n(rst_n), .grade_i(grade_i),
        .up_i(up_i), .down_i(down_i), .load_i(load_i),
        .ld_coarse_i(ld_coarse_i), .ld_clkd_i(ld_clkd_i),
        .ld_tap_i(ld_tap_i), .ld_pi_i(ld_pi_i),
        .coarse_o(coarse_o), .clkd_o(clkd_o), .tap_o(tap_o), .pi_o(pi_o),
        .byp_en_o(byp_en_o), .byp_sel_o(byp_sel_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic int tmax(input int g);
        if (g == 1) return 10;
        if (g == 2) return 13;
        return 12;
    endfunction

    // Model bypass bits from R7.
    task automatic model_byp(input int g);
        int t0, t1, p0, p1;
        if (g == 1)      begin t0 = 2; t1 = 8;  p0 = 6; p1 = 7; end
        else if (g == 2) begin t0 = 3; t1 = 11; p0 = 6; p1 = 4; end
        else             begin t0 = 3; t1 = 10; p0 = 2; p1 = 3; end
        if (m_tp < t0 || (m_tp == t0 && m_pi < p0))      begin m_en = 1; m_sel = 1; end
        else if (m_tp < t1 || (m_tp == t1 && m_pi < p1)) begin m_en = 0; m_sel = 0; end
        else                                             begin m_en = 1; m_sel = 0; end
    endtask

    // Model one up step (R2, R3, R4); returns requirement tag.
    task automatic model_up(input int g, output string tag);
        m_done = 1; m_err = 0;
        if (m_pi < 6)            begin m_pi++; tag = "R2"; end
        else if (m_tp < tmax(g)) begin m_pi = 0; m_tp++; tag = "R3"; end
        else if (m_cd < 2)       begin m_pi = 0; m_tp = 0; m_cd++; tag = "R4"; end
        else if (m_co < 1)       begin m_pi = 0; m_tp = 0; m_cd--; m_co = 1; tag = "R4"; end
        else begin m_done = 0; m_err = 1; tag = "R4"; end
        if (m_done == 1) model_byp(g);
    endtask

    // Model one down step (R5, R6).
    task automatic model_down(input int g, output string tag);
        m_done = 1; m_err = 0; tag = "R5";
        if (m_pi > 0)      m_pi--;
        else if (m_tp > 0) begin m_pi = 6; m_tp--; end
        else if (m_cd > 0) begin m_pi = 6; m_tp = tmax(g); m_cd--; end
        else if (m_co > 0) begin m_pi = 6; m_tp = tmax(g); m_cd++; m_co = 0; end
        else begin m_done = 0; m_err = 1; tag = "R6"; end
        if (m_done == 1) model_byp(g);
    endtask

    task automatic check_all(input string tag, input string btag);
        checks++;
        if (coarse_o != m_co[0] || clkd_o != m_cd[1:0] || tap_o != m_tp[3:0] ||
            pi_o != m_pi[2:0] || done_o != m_done[0] || err_o != m_err[0]) begin
            fails++;
            $display("FAIL %s: actual co=%0d cd=%0d tap=%0d pi=%0d done=%0d err=%0d expected co=%0d cd=%0d tap=%0d pi=%0d done=%0d err=%0d",
                     tag, coarse_o, clkd_o, tap_o, pi_o, done_o, err_o,
                     m_co, m_cd, m_tp, m_pi, m_done, m_err);
        end
        checks++;
        if (byp_en_o != m_en[0] || byp_sel_o != m_sel[0]) begin
            fails++;
            $display("FAIL %s: actual bypass en=%0d sel=%0d expected en=%0d sel=%0d",
                     btag, byp_en_o, byp_sel_o, m_en, m_sel);
        end
    endtask

    // kind: 0 up, 1 down, 2 both, 3 load, 4 idle, 5 grade change + idle.
    task automatic do_op(input int kind, input int g, input int lco, input int lcd,
                         input int ltp, input int lpi, input int extra_up);
        string tag;
        string btag;
        @(negedge clk);
        btag = "R7";
        grade_i = g[1:0];
        case (kind)
            0: begin up_i = 1'b1; model_up(g, tag); end
            1: begin down_i = 1'b1; model_down(g, tag); end
            2: begin up_i = 1'b1; down_i = 1'b1; m_done = 0; m_err = 0; tag = "R8"; btag = "R8"; end
            3: begin
                load_i = 1'b1; up_i = extra_up[0];
                ld_coarse_i = lco[0]; ld_clkd_i = lcd[1:0];
                ld_tap_i = ltp[3:0]; ld_pi_i = lpi[2:0];
                m_co = lco; m_cd = lcd; m_tp = ltp; m_pi = lpi;
                m_done = 0; m_err = 0; model_byp(g); tag = "R9"; btag = "R9";
            end
            4: begin m_done = 0; m_err = 0; tag = "R10"; end
            default: begin m_done = 0; m_err = 0; tag = "R11"; btag = "R11"; end
        endcase
        @(negedge clk);
        check_all(tag, btag);
        up_i = 1'b0; down_i = 1'b0; load_i = 1'b0;
        if (kind == 0 || kind == 1) begin
            // R10: the pulse lasts one cycle only.
            m_done = 0; m_err = 0;
            @(negedge clk);
            check_all("R10", "R10");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        int g;
        seed = $urandom(32'h1d5e);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_co = 0; m_cd = 0; m_tp = 0; m_pi = 0; m_en = 1; m_sel = 1; m_done = 0; m_err = 0;
        check_all("R1", "R1");

        // R6: down from all-zero is rejected.
        do_op(1, 0, 0, 0, 0, 0, 0);
        // R4: top of range rejects up, per grade; carry into coarse from clkd 2.
        for (int gg = 0; gg < 4; gg++) begin
            do_op(3, gg, 1, 1, tmax(gg), 6, 0);
            do_op(0, gg, 0, 0, 0, 0, 0);
            do_op(3, gg, 0, 2, tmax(gg), 6, 0);
            do_op(0, gg, 0, 0, 0, 0, 0);
            do_op(1, gg, 0, 0, 0, 0, 0);
            do_op(1, gg, 0, 0, 0, 0, 0);
        end
        // R9: load wins over a simultaneous up request.
        do_op(3, 2, 0, 1, 5, 3, 1);
        // R3: full sweep up grade 1 until rejection.
        do_op(3, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 400 && m_err == 0; i++) do_op(0, 1, 0, 0, 0, 0, 0);
        // R5: sweep down back to zero.
        for (int i = 0; i < 400 && m_err == 0; i++) do_op(1, 1, 0, 0, 0, 0, 0);
        // R11: grade change alone keeps bypass bits.
        do_op(3, 0, 0, 0, 10, 2, 0);
        do_op(5, 1, 0, 0, 0, 0, 0);
        do_op(5, 2, 0, 0, 0, 0, 0);

        // Random mix.
        g = 0;
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 42)      do_op(0, g, 0, 0, 0, 0, 0);
            else if (r < 80) do_op(1, g, 0, 0, 0, 0, 0);
            else if (r < 85) do_op(2, g, 0, 0, 0, 0, 0);
            else if (r < 92) begin
                int lcd;
                lcd = $urandom_range(0, 2);
                do_op(3, g, $urandom_range(0, 1), lcd, $urandom_range(0, tmax(g)),
                      $urandom_range(0, 6), $urandom_range(0, 1));
            end else if (r < 96) do_op(4, g, 0, 0, 0, 0, 0);
            else begin
                g = $urandom_range(0, 3);
                do_op(5, g, 0, 0, 0, 0, 0);
                // Keep the model setting legal for the new grade.
                if (m_tp > tmax(g)) do_op(3, g, m_co, m_cd, tmax(g), m_pi, 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule